// File: doc/BRIEF.md
# Counter Timebase Prescaler and Interrupt Router

This block supplies the clock enable for a programmable 16-bit counter channel and converts that channel's output into a host interrupt request. It divides the system clock into a 1 MHz enable pulse. Two decade divider stages then derive 100 kHz and 10 kHz pulses from it. A two-bit rate select picks which of the three pulses drives the counter's count enable. The default selection is 1 MHz, which is also the highest count rate.

The counter output arrives from outside the clock domain. It is passed through a two-flop synchroniser. A low-to-high change on it sets a pending interrupt flag, and the flag stays set until the host acknowledges it. A three-bit route select steers the flag onto one of five host interrupt lines (IRQ2, IRQ3, IRQ4, IRQ5, IRQ7) or onto none. With no route, every line stays low, so lines that are unused or shared remain free.

Top module: `tmr_clk_irq_router`

## Requirements
- R1: `tick_base` is a single-cycle pulse that repeats exactly every BASE_DIV system clocks.
- R2: The 100 kHz pulse repeats every 10 base pulses and only ever occurs in a cycle that also carries a base pulse.
- R3: The 10 kHz pulse repeats every 100 base pulses and only ever occurs in a cycle that also carries a 100 kHz pulse.
- R4: `cnt_clk_en` follows the pulse chosen by `rate_sel`: 0 selects 1 MHz, 1 selects 100 kHz, 2 selects 10 kHz, and 3 falls back to 1 MHz.
- R5: After synchronous reset, `irq_pending` is 0 and all `irq_lines` are 0.
- R6: A 0-to-1 change on `cnt_out` that is held steady sets `irq_pending`. The flag is visible after the third rising clock edge that follows the change.
- R7: A 1-to-0 change on `cnt_out`, or a steady level, never sets `irq_pending`.
- R8: When `irq_ack` is high and no rising edge is detected in the same cycle, `irq_pending` is 0 after the next clock edge.
- R9: A detected rising edge that coincides with `irq_ack` wins, and `irq_pending` stays 1.
- R10: `irq_route` encoding: 1→IRQ2 (bit 0), 2→IRQ3 (bit 1), 3→IRQ4 (bit 2), 4→IRQ5 (bit 3), 5→IRQ7 (bit 4). The values 0, 6 and 7 drive no line. The chosen line equals `irq_pending`, and no more than one line is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | Counter clock rate select |
| irq_route | input | 3 | Interrupt line route select |
| cnt_out | input | 1 | Counter channel output, asynchronous |
| irq_ack | input | 1 | Clears the pending interrupt |
| tick_base | output | 1 | 1 MHz enable pulse |
| cnt_clk_en | output | 1 | Selected count enable for the counter |
| irq_pending | output | 1 | Pending interrupt flag |
| irq_lines | output | 5 | Host interrupt lines {IRQ7,IRQ5,IRQ4,IRQ3,IRQ2} |

## Verification
Each of the four rate-select codes is held while the interval between `cnt_clk_en` pulses is measured. The measured interval separates the three divide ratios, and code 3 must give the same interval as code 0. The counter output is driven through rising edges, falling edges and held levels, so a level detector can be told apart from an edge detector. An acknowledge is also timed to land in the very cycle the edge is detected, which exposes the wrong priority between the two. Randomly chosen route codes, including the unused ones, are checked against a computed line mask with the flag both set and clear.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

    localparam int NUM_LINES = 5;
    localparam int DECADE    = 10;

    typedef enum logic [1:0] {
        RATE_1M   = 2'd0,
        RATE_100K = 2'd1,
        RATE_10K  = 2'd2,
        RATE_ALT  = 2'd3
    } rate_sel_e;

    typedef enum logic [2:0] {
        ROUTE_NONE = 3'd0,
        ROUTE_IRQ2 = 3'd1,
        ROUTE_IRQ3 = 3'd2,
        ROUTE_IRQ4 = 3'd3,
        ROUTE_IRQ5 = 3'd4,
        ROUTE_IRQ7 = 3'd5,
        ROUTE_RSV6 = 3'd6,
        ROUTE_RSV7 = 3'd7
    } route_e;

    typedef struct packed {
        logic base;
        logic dec1;
        logic dec2;
    } ticks_t;

    // Route code that selects line index idx
    function automatic logic [2:0] route_code(input int idx);
        return 3'(idx + 1);
    endfunction

endpackage

// File: rtl/tick_div.sv
module tick_div #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic en_in,
    output logic en_out
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          at_last;

    assign at_last = (cnt_q == LAST);
    assign en_out  = en_in && at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (en_in) begin
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/edge_pending.sv
module edge_pending #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_async,
    input  logic ack,
    output logic rise,
    output logic pending
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], sig_async};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rise = sync_q[SYNC_STAGES-1] && !prev_q;

    always_ff @(posedge clk) begin
        if (rst)       pending <= 1'b0;
        else if (rise) pending <= 1'b1;
        else if (ack)  pending <= 1'b0;
    end
endmodule

// File: rtl/irq_router.sv
module irq_router
    import tmr_irq_pkg::*;
(
    input  logic                 req,
    input  logic [2:0]           route,
    output logic [NUM_LINES-1:0] lines
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign lines[i] = req && (route == route_code(i));
    end
endmodule

// File: rtl/tmr_clk_irq_router.sv
module tmr_clk_irq_router
    import tmr_irq_pkg::*;
#(
    parameter int BASE_DIV    = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] rate_sel,
    input  logic [2:0] irq_route,
    input  logic       cnt_out,
    input  logic       irq_ack,
    output logic       tick_base,
    output logic       cnt_clk_en,
    output logic       irq_pending,
    output logic [4:0] irq_lines
);
    ticks_t ticks;
    logic   t_base, t_dec1, t_dec2;
    logic   rise_det;

    tick_div #(.DIV(BASE_DIV)) u_div_base (
        .clk(clk), .rst(rst), .en_in(1'b1), .en_out(t_base));
    tick_div #(.DIV(DECADE)) u_div_dec1 (
        .clk(clk), .rst(rst), .en_in(t_base), .en_out(t_dec1));
    tick_div #(.DIV(DECADE)) u_div_dec2 (
        .clk(clk), .rst(rst), .en_in(t_dec1), .en_out(t_dec2));

    assign ticks = '{base: t_base, dec1: t_dec1, dec2: t_dec2};

    always_comb begin
        case (rate_sel_e'(rate_sel))
            RATE_100K: cnt_clk_en = ticks.dec1;
            RATE_10K:  cnt_clk_en = ticks.dec2;
            default:   cnt_clk_en = ticks.base;
        endcase
    end

    assign tick_base = ticks.base;

    edge_pending #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst(rst), .sig_async(cnt_out), .ack(irq_ack),
        .rise(rise_det), .pending(irq_pending));

    irq_router u_router (
        .req(irq_pending), .route(irq_route), .lines(irq_lines));
endmodule

// File: rtl/tmr_clk_irq_router_chk.sv
module tmr_clk_irq_router_chk (
    input logic       clk,
    input logic       rst,
    input logic       irq_ack,
    input logic       irq_pending,
    input logic [4:0] irq_lines,
    input logic       t_base,
    input logic       t_dec1,
    input logic       t_dec2,
    input logic       rise_det
);
    // R2
    dec1_on_base_chk: assert property (@(posedge clk) disable iff (rst)
        t_dec1 |-> t_base);
    // R3
    dec2_on_dec1_chk: assert property (@(posedge clk) disable iff (rst)
        t_dec2 |-> t_dec1);
    // R6
    rise_sets_chk: assert property (@(posedge clk) disable iff (rst)
        rise_det |=> irq_pending);
    // R7
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq_pending && !rise_det) |=> !irq_pending);
    // R8
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !rise_det) |=> !irq_pending);
    // R10
    one_line_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_lines));
    // R10
    idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_pending |-> (irq_lines == 5'd0));
endmodule

bind tmr_clk_irq_router tmr_clk_irq_router_chk u_chk (
    .clk(clk), .rst(rst), .irq_ack(irq_ack), .irq_pending(irq_pending),
    .irq_lines(irq_lines), .t_base(t_base), .t_dec1(t_dec1),
    .t_dec2(t_dec2), .rise_det(rise_det));

// File: tb/tmr_clk_irq_router_bench.sv
module tmr_clk_irq_router_bench;
    localparam int BASE_DIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] rate_sel = 2'd0;
    logic [2:0] irq_route = 3'd0;
    logic       cnt_out = 1'b0;
    logic       irq_ack = 1'b0;
    logic       tick_base, cnt_clk_en, irq_pending;
    logic [4:0] irq_lines;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    tmr_clk_irq_router #(.BASE_DIV(BASE_DIV)) u_tmr_clk_irq_router (
        .clk(clk), .rst(rst), .rate_sel(rate_sel), .irq_route(irq_route),
        .cnt_out(cnt_out), .irq_ack(irq_ack), .tick_base(tick_base),
        .cnt_clk_en(cnt_clk_en), .irq_pending(irq_pending),
        .irq_lines(irq_lines));

    function automatic logic [4:0] exp_lines(input logic [2:0] r, input logic p);
        if (!p || r == 3'd0 || r > 3'd5) return 5'd0;
        return 5'(1) << (r - 3'd1);
    endfunction

    function automatic int exp_period(input logic [1:0] s);
        case (s)
            2'd1:    return BASE_DIV * 10;
            2'd2:    return BASE_DIV * 100;
            default: return BASE_DIV;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    // Measure the interval between successive pulses of sig (0=base, 1=cnt_clk_en)
    task automatic measure(input bit use_en, output int period, output bit single);
        int n = 0;
        while (!(use_en ? cnt_clk_en : tick_base)) @(negedge clk);
        @(negedge clk);
        single = !(use_en ? cnt_clk_en : tick_base) || (use_en ? exp_period(rate_sel) == 1 : BASE_DIV == 1);
        n = 1;
        while (!(use_en ? cnt_clk_en : tick_base) && n < 2000) begin
            @(negedge clk);
            n++;
        end
        period = n;
    endtask

    task automatic raise_and_check(input string req);
        cnt_out = 1'b1;
        repeat (2) @(negedge clk);
        check(req, irq_pending, 0);
        @(negedge clk);
        check(req, irq_pending, 1);
    endtask

    task automatic do_ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        int per;
        bit single;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R5 reset state
        check("R5 pending", irq_pending, 0);
        check("R5 lines", irq_lines, 0);
        rst = 1'b0;
        @(negedge clk);

        // R1 base period and pulse width
        measure(1'b0, per, single);
        check("R1 period", per, BASE_DIV);
        check("R1 single", single, 1);

        // R4 with R2/R3 periods through every select code
        for (int s = 0; s < 4; s++) begin
            rate_sel = 2'(s);
            @(negedge clk);
            measure(1'b1, per, single);
            check(s == 1 ? "R2 R4 period" : s == 2 ? "R3 R4 period" : "R4 period",
                  per, exp_period(2'(s)));
            check("R4 single", single, 1);
        end

        // R6 rise sets, R10 lines with route IRQ7
        irq_route = 3'd5;
        raise_and_check("R6");
        check("R10 lines", irq_lines, exp_lines(3'd5, 1'b1));
        // R7 steady high, no re-trigger after ack
        do_ack();
        check("R8 ack", irq_pending, 0);
        repeat (5) @(negedge clk);
        check("R7 steady", irq_pending, 0);
        // R7 falling edge
        cnt_out = 1'b0;
        repeat (5) @(negedge clk);
        check("R7 fall", irq_pending, 0);
        check("R7 lines", irq_lines, 0);

        // R9 coincident edge and ack: set pending first
        raise_and_check("R6 prep");
        cnt_out = 1'b0;
        repeat (4) @(negedge clk);
        cnt_out = 1'b1;
        @(negedge clk);
        @(negedge clk);
        irq_ack = 1'b1;      // sampled at the edge where the rise is detected
        @(negedge clk);
        irq_ack = 1'b0;
        check("R9 edge wins", irq_pending, 1);
        do_ack();
        check("R8 clear", irq_pending, 0);
        cnt_out = 1'b0;
        repeat (4) @(negedge clk);

        // Random routes and edge/ack mix, R10 with R6/R8
        for (int i = 0; i < 30; i++) begin
            logic [2:0] r;
            r = 3'($urandom_range(0, 7));
            irq_route = r;
            @(negedge clk);
            check("R10 idle", irq_lines, exp_lines(r, 1'b0));
            raise_and_check("R6 rand");
            check("R10 routed", irq_lines, exp_lines(r, 1'b1));
            repeat ($urandom_range(0, 3)) @(negedge clk);
            do_ack();
            check("R8 rand", irq_pending, 0);
            check("R10 cleared", irq_lines, 0);
            cnt_out = 1'b0;
            repeat (3 + $urandom_range(0, 3)) @(negedge clk);
            check("R7 rand fall", irq_pending, 0);
        end

        finish_run();
    end
endmodule